// File: doc/BRIEF.md
# Interrupt Pin Sequencer with End-of-Interrupt Handling

This block watches a bank of interrupt input lines and turns them into delivery messages, one at a time, using the redirection settings held for each pin. Each pin has a polarity, a trigger mode (edge or level), a mask and a payload made of a vector, a destination ID, a destination mode and a delivery mode. The block keeps a request bit and a remote-pending bit for each pin. A message leaves on a valid/ready port and carries the pin's payload, with the level flag set and the shorthand field zero.

Edge pins request service on each inactive-to-active change of their effective level. Level pins are blocked while their remote-pending bit is set. An end-of-interrupt input that carries a vector unblocks level pins, and a per-pin retrigger strobe serves a level pin again after its settings are rewritten. A request that arrives while the pin is already busy is counted as coalesced and reported on a one-cycle pulse. A map of every vector that appears in the table is also kept, one bit per vector value.

Top module: `irq_pin_sequencer`

## Requirements
- R1: The effective level of a pin is `line_in` XOR `cfg_polarity`. With polarity 1, a pin is active while its line is low.
- R2: An unmasked edge pin (`cfg_trig_level`=0) requests one delivery for each 0-to-1 change of its effective level. Holding the level active gives no further message.
- R3: An edge pin whose earlier request is still waiting in the pin queue, and not yet taken into the output slot, drops a new rise and pulses `coal_pulse` for that pin one cycle after the rise.
- R4: A level pin (`cfg_trig_level`=1) requests delivery on a rise only while its remote-pending bit is clear and no request of its own is waiting or in the output slot. Otherwise the rise is coalesced. An accepted message from a level pin sets that pin's remote-pending bit.
- R5: A masked pin produces neither a message nor a coalesced pulse. A pending request is dropped once its pin becomes masked.
- R6: A message carries the pin index and the pin's vector, destination ID, destination mode, trigger mode and delivery mode, with `msg_level_asserted`=1 and `msg_shorthand`=2'b00.
- R7: An end-of-interrupt acts on every pin whose vector equals `eoi_vector`. When `eoi_level`=1, it clears the pin's remote-pending bit and requests delivery again if the pin is unmasked and its request bit is set. When `eoi_level`=0, the remote-pending bits are left unchanged.
- R8: A `retrig_strobe` pulse on an unmasked level pin whose request bit is set requests a delivery. It has no effect on edge pins or on pins whose request bit is clear.
- R9: Requests waiting in the same cycle are issued in ascending pin order, one per accepted handshake. While `msg_valid`=1 and `msg_ready`=0, the message holds steady.
- R10: Bit v of `vec_map` is 1 exactly when some pin's vector equals v. The map follows a table change one cycle later.
- R11: Reset clears all request and remote-pending bits and holds `msg_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | NUM_PINS | Raw interrupt line levels |
| cfg_polarity | input | NUM_PINS | 1 = pin is active low |
| cfg_trig_level | input | NUM_PINS | 1 = level trigger, 0 = edge trigger |
| cfg_mask | input | NUM_PINS | 1 = pin masked |
| cfg_dest_mode | input | NUM_PINS | Destination mode bit per pin |
| cfg_vector | input | NUM_PINS*VEC_W | Vector per pin, pin p at bits [p*VEC_W +: VEC_W] |
| cfg_dest_id | input | NUM_PINS*DEST_W | Destination ID per pin |
| cfg_dlv_mode | input | NUM_PINS*DLV_W | Delivery mode per pin |
| retrig_strobe | input | NUM_PINS | Serve this pin again after its settings were rewritten |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | VEC_W | Vector being acknowledged |
| eoi_level | input | 1 | 1 = level-type end-of-interrupt |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer takes the message |
| msg_pin | output | IDX_W | Source pin index |
| msg_dest_id | output | DEST_W | Destination ID |
| msg_vector | output | VEC_W | Vector |
| msg_dest_mode | output | 1 | Destination mode |
| msg_trig_level | output | 1 | Trigger mode of the source pin |
| msg_dlv_mode | output | DLV_W | Delivery mode |
| msg_level_asserted | output | 1 | Always 1 |
| msg_shorthand | output | 2 | Always 2'b00 |
| coal_pulse | output | NUM_PINS | One-cycle coalesced-request pulse per pin |
| vec_map | output | 2**VEC_W | Vectors used by the table |

## Verification
All input changes go through registers, so results arrive on a fixed schedule. A line rise, end-of-interrupt or strobe sets a pin request on the first clock edge, and a coalesced pulse shows then. The request reaches the output slot on the second edge. A table change reaches `vec_map` on the first edge, and the next queued message fills the slot on the same edge that accepts the previous one. The bench drives inputs on falling edges and samples on a falling edge exactly one or two rising edges later, matching that schedule. It also checks the held-message window several cycles into a stall, and the absence of a message at points where one would have been due.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

   localparam logic       TRIG_EDGE      = 1'b0;
   localparam logic       TRIG_LEVEL     = 1'b1;
   localparam logic [1:0] SHORTHAND_NONE = 2'b00;

   // index width for a pin count, never below one bit
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/irq_pin_state.sv
module irq_pin_state
   import irq_seq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic line,
   input  logic polarity,
   input  logic trig_level,
   input  logic mask,
   input  logic strobe,
   input  logic eoi_hit,
   input  logic eoi_level,
   input  logic load,
   input  logic inflight,
   input  logic accept_level,
   output logic pend,
   output logic coal,
   output logic remote
);

   logic req_q;
   logic eff_lvl, rise, busy;
   logic svc_rise, svc_eoi, svc_strobe, eoi_clr;

   always_comb begin
      eff_lvl    = line ^ polarity;
      rise       = eff_lvl & ~req_q;
      busy       = pend | ((trig_level == TRIG_LEVEL) & (remote | inflight));
      svc_rise   = rise & ~mask & ~busy;
      eoi_clr    = eoi_hit & eoi_level;
      svc_eoi    = eoi_clr & ~mask & req_q;
      svc_strobe = strobe & (trig_level == TRIG_LEVEL) & req_q & ~mask;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         pend   <= 1'b0;
         remote <= 1'b0;
         coal   <= 1'b0;
      end else begin
         req_q <= eff_lvl;
         pend  <= (pend & ~load & ~mask) | svc_rise | svc_eoi | svc_strobe;
         coal  <= rise & ~mask & busy;
         if (accept_level)
            remote <= 1'b1;
         else if (eoi_clr)
            remote <= 1'b0;
      end
   end

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
   parameter int N     = 24,
   parameter int IDX_W = 5
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   if (N < 1) begin : g_bad_n
      $error("irq_lowest_pick: N must be at least 1");
   end

   if (N == 1) begin : g_single
      assign any = req[0];
      assign idx = '0;
   end else begin : g_multi
      always_comb begin
         any = |req;
         idx = '0;
         for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) idx = IDX_W'(k);
         end
      end
   end

endmodule

// File: rtl/irq_vec_map.sv
module irq_vec_map #(
   parameter int NUM_PINS = 24,
   parameter int VEC_W    = 8,
   localparam int MAP_W   = 1 << VEC_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_PINS*VEC_W-1:0] vectors,
   output logic [MAP_W-1:0]          vec_map
);

   logic [MAP_W-1:0] map_n;

   always_comb begin
      map_n = '0;
      for (int p = 0; p < NUM_PINS; p++) begin
         map_n[vectors[p*VEC_W +: VEC_W]] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) vec_map <= '0;
      else        vec_map <= map_n;
   end

endmodule

// File: rtl/irq_pin_sequencer.sv
module irq_pin_sequencer
   import irq_seq_pkg::*;
#(
   parameter int NUM_PINS = 24,
   parameter int VEC_W    = 8,
   parameter int DEST_W   = 8,
   parameter int DLV_W    = 3,
   localparam int IDX_W   = idx_width(NUM_PINS),
   localparam int MAP_W   = 1 << VEC_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_PINS-1:0]        line_in,
   input  logic [NUM_PINS-1:0]        cfg_polarity,
   input  logic [NUM_PINS-1:0]        cfg_trig_level,
   input  logic [NUM_PINS-1:0]        cfg_mask,
   input  logic [NUM_PINS-1:0]        cfg_dest_mode,
   input  logic [NUM_PINS*VEC_W-1:0]  cfg_vector,
   input  logic [NUM_PINS*DEST_W-1:0] cfg_dest_id,
   input  logic [NUM_PINS*DLV_W-1:0]  cfg_dlv_mode,
   input  logic [NUM_PINS-1:0]        retrig_strobe,
   input  logic                       eoi_valid,
   input  logic [VEC_W-1:0]           eoi_vector,
   input  logic                       eoi_level,
   output logic                       msg_valid,
   input  logic                       msg_ready,
   output logic [IDX_W-1:0]           msg_pin,
   output logic [DEST_W-1:0]          msg_dest_id,
   output logic [VEC_W-1:0]           msg_vector,
   output logic                       msg_dest_mode,
   output logic                       msg_trig_level,
   output logic [DLV_W-1:0]           msg_dlv_mode,
   output logic                       msg_level_asserted,
   output logic [1:0]                 msg_shorthand,
   output logic [NUM_PINS-1:0]        coal_pulse,
   output logic [MAP_W-1:0]           vec_map
);

   if (NUM_PINS < 1 || NUM_PINS > 256) begin : g_bad_pins
      $error("irq_pin_sequencer: NUM_PINS out of range 1..256");
   end
   if (VEC_W < 1 || VEC_W > 12) begin : g_bad_vec
      $error("irq_pin_sequencer: VEC_W out of range 1..12");
   end
   if (DEST_W < 1 || DLV_W < 1) begin : g_bad_fields
      $error("irq_pin_sequencer: field widths must be positive");
   end

   logic [NUM_PINS-1:0] pin_pend, pin_remote;
   logic [NUM_PINS-1:0] load_vec, inflight_vec, accept_lvl_vec, eoi_hit_vec;
   logic                pick_any, slot_free, load, accept;
   logic [IDX_W-1:0]    pick_idx;

   assign accept    = msg_valid & msg_ready;
   assign slot_free = ~msg_valid | msg_ready;
   assign load      = slot_free & pick_any;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      assign load_vec[i]       = load & (pick_idx == IDX_W'(i));
      assign inflight_vec[i]   = msg_valid & (msg_pin == IDX_W'(i));
      assign accept_lvl_vec[i] = accept & (msg_trig_level == TRIG_LEVEL) & (msg_pin == IDX_W'(i));
      assign eoi_hit_vec[i]    = eoi_valid & (cfg_vector[i*VEC_W +: VEC_W] == eoi_vector);

      irq_pin_state u_state (
         .clk          (clk),
         .rst_n        (rst_n),
         .line         (line_in[i]),
         .polarity     (cfg_polarity[i]),
         .trig_level   (cfg_trig_level[i]),
         .mask         (cfg_mask[i]),
         .strobe       (retrig_strobe[i]),
         .eoi_hit      (eoi_hit_vec[i]),
         .eoi_level    (eoi_level),
         .load         (load_vec[i]),
         .inflight     (inflight_vec[i]),
         .accept_level (accept_lvl_vec[i]),
         .pend         (pin_pend[i]),
         .coal         (coal_pulse[i]),
         .remote       (pin_remote[i])
      );
   end

   irq_lowest_pick #(.N(NUM_PINS), .IDX_W(IDX_W)) u_pick (
      .req (pin_pend & ~cfg_mask),
      .any (pick_any),
      .idx (pick_idx)
   );

   irq_vec_map #(.NUM_PINS(NUM_PINS), .VEC_W(VEC_W)) u_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .vectors (cfg_vector),
      .vec_map (vec_map)
   );

   // output slot: holds one message until the handshake completes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msg_valid      <= 1'b0;
         msg_pin        <= '0;
         msg_dest_id    <= '0;
         msg_vector     <= '0;
         msg_dest_mode  <= 1'b0;
         msg_trig_level <= TRIG_EDGE;
         msg_dlv_mode   <= '0;
      end else if (slot_free) begin
         msg_valid <= pick_any;
         if (pick_any) begin
            msg_pin        <= pick_idx;
            msg_dest_id    <= cfg_dest_id[pick_idx*DEST_W +: DEST_W];
            msg_vector     <= cfg_vector[pick_idx*VEC_W +: VEC_W];
            msg_dest_mode  <= cfg_dest_mode[pick_idx];
            msg_trig_level <= cfg_trig_level[pick_idx];
            msg_dlv_mode   <= cfg_dlv_mode[pick_idx*DLV_W +: DLV_W];
         end
      end
   end

   assign msg_level_asserted = 1'b1;
   assign msg_shorthand      = SHORTHAND_NONE;

endmodule

// File: rtl/irq_seq_checker.sv
module irq_seq_checker #(
   parameter int NUM_PINS = 24,
   parameter int IDX_W    = 5,
   parameter int VEC_W    = 8,
   parameter int MAP_W    = 256
) (
   input logic                clk,
   input logic                rst_n,
   input logic                msg_valid,
   input logic                msg_ready,
   input logic [IDX_W-1:0]    msg_pin,
   input logic [VEC_W-1:0]    msg_vector,
   input logic                msg_trig_level,
   input logic [NUM_PINS-1:0] cfg_mask,
   input logic [NUM_PINS-1:0] coal_pulse,
   input logic [NUM_PINS-1:0] pin_remote,
   input logic [MAP_W-1:0]    vec_map
);

   // R9: a stalled message keeps its content
   assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && !msg_ready |=> msg_valid && $stable(msg_pin) && $stable(msg_vector));

   // R4: accepting a level message blocks its pin
   assert_remote_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && msg_ready && msg_trig_level |=> pin_remote[$past(msg_pin)]);

   // R5: masked pins never report coalescing
   assert_masked_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (coal_pulse & $past(cfg_mask)) == '0);

   // R10: no more vectors marked than pins
   assert_map_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(vec_map) <= NUM_PINS);

   // R11: reset empties the output slot
   assert_reset_idle_R11: assert property (@(posedge clk)
      !rst_n |=> !msg_valid);

endmodule

bind irq_pin_sequencer irq_seq_checker #(
   .NUM_PINS (NUM_PINS),
   .IDX_W    (IDX_W),
   .VEC_W    (VEC_W),
   .MAP_W    (MAP_W)
) u_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .msg_valid      (msg_valid),
   .msg_ready      (msg_ready),
   .msg_pin        (msg_pin),
   .msg_vector     (msg_vector),
   .msg_trig_level (msg_trig_level),
   .cfg_mask       (cfg_mask),
   .coal_pulse     (coal_pulse),
   .pin_remote     (pin_remote),
   .vec_map        (vec_map)
);

// File: tb/tb_irq_pin_sequencer.sv
module tb_irq_pin_sequencer;

   localparam int NP = 24;
   localparam int VW = 8;
   localparam int DW = 8;
   localparam int LW = 3;
   localparam int IW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5ns clk = ~clk;

   logic [NP-1:0] line_in, pol, trig, mask, dmode, strobe;
   logic [VW-1:0] b_vec [NP];
   logic [DW-1:0] b_dst [NP];
   logic [LW-1:0] b_dlv [NP];
   logic [NP*VW-1:0] vec_flat;
   logic [NP*DW-1:0] dst_flat;
   logic [NP*LW-1:0] dlv_flat;
   logic eoi_valid, eoi_level, msg_ready;
   logic [VW-1:0] eoi_vector;

   logic msg_valid, msg_dest_mode, msg_trig_level, msg_level_asserted;
   logic [IW-1:0] msg_pin;
   logic [DW-1:0] msg_dest_id;
   logic [VW-1:0] msg_vector;
   logic [LW-1:0] msg_dlv_mode;
   logic [1:0] msg_shorthand;
   logic [NP-1:0] coal_pulse;
   logic [255:0] vec_map;

   always_comb begin
      for (int p = 0; p < NP; p++) begin
         vec_flat[p*VW +: VW] = b_vec[p];
         dst_flat[p*DW +: DW] = b_dst[p];
         dlv_flat[p*LW +: LW] = b_dlv[p];
      end
   end

   irq_pin_sequencer dut (
      .clk(clk), .rst_n(rst_n), .line_in(line_in), .cfg_polarity(pol),
      .cfg_trig_level(trig), .cfg_mask(mask), .cfg_dest_mode(dmode),
      .cfg_vector(vec_flat), .cfg_dest_id(dst_flat), .cfg_dlv_mode(dlv_flat),
      .retrig_strobe(strobe), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
      .eoi_level(eoi_level), .msg_valid(msg_valid), .msg_ready(msg_ready),
      .msg_pin(msg_pin), .msg_dest_id(msg_dest_id), .msg_vector(msg_vector),
      .msg_dest_mode(msg_dest_mode), .msg_trig_level(msg_trig_level),
      .msg_dlv_mode(msg_dlv_mode), .msg_level_asserted(msg_level_asserted),
      .msg_shorthand(msg_shorthand), .coal_pulse(coal_pulse), .vec_map(vec_map)
   );

   int checks = 0;
   int failures = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_none(input string tag);
      chk(msg_valid == 1'b0, tag, 64'(msg_valid), 64'd0);
   endtask

   // compare the slot against pin p, then accept it on the next edge
   task automatic expect_msg(input int p, input string tag);
      chk(msg_valid == 1'b1, {tag, " valid"}, 64'(msg_valid), 64'd1);
      chk(msg_pin == IW'(p), {tag, " pin"}, 64'(msg_pin), 64'(p));
      chk(msg_vector == b_vec[p], {tag, " vector"}, 64'(msg_vector), 64'(b_vec[p]));
      chk(msg_dest_id == b_dst[p] && msg_dlv_mode == b_dlv[p] && msg_dest_mode == dmode[p]
          && msg_trig_level == trig[p], {tag, " R6 payload"},
          {msg_dest_id, msg_dlv_mode, msg_dest_mode, msg_trig_level},
          {b_dst[p], b_dlv[p], dmode[p], trig[p]});
      chk(msg_level_asserted == 1'b1 && msg_shorthand == 2'b00, {tag, " R6 fixed fields"},
          {msg_level_asserted, msg_shorthand}, 64'b100);
      msg_ready = 1'b1;
      step(1);
      msg_ready = 1'b0;
   endtask

   task automatic eoi_pulse(input logic [VW-1:0] v, input logic lvl);
      eoi_valid = 1'b1; eoi_vector = v; eoi_level = lvl;
      step(1);
      eoi_valid = 1'b0;
   endtask

   task automatic t_reset_state();
      chk(msg_valid == 1'b0, "R11 valid low in reset", 64'(msg_valid), 0);
      chk(coal_pulse == '0, "R11 no coalesce in reset", 64'(coal_pulse), 0);
   endtask

   task automatic t_vec_map_r10();
      chk(vec_map[8'h20] && vec_map[8'h37], "R10 used vectors marked", 64'(vec_map[8'h37]), 1);
      chk(!vec_map[8'h38], "R10 unused vector clear", 64'(vec_map[8'h38]), 0);
      chk($countones(vec_map) == NP, "R10 count", 64'($countones(vec_map)), 64'(NP));
      b_vec[5] = 8'h90;
      step(1);
      chk(vec_map[8'h90] && !vec_map[8'h25], "R10 follows table change",
          {vec_map[8'h90], vec_map[8'h25]}, 64'b10);
   endtask

   task automatic t_edge_polarity_r1_r2();
      pol[3] = 1'b1; line_in[3] = 1'b1; step(1);
      mask[3] = 1'b0; step(1);
      expect_none("R1 active-low pin idle while line high");
      line_in[3] = 1'b0;
      step(2);
      expect_msg(3, "R1 R2 edge rise on active-low pin");
      step(4);
      expect_none("R2 held level gives one message");
      line_in[3] = 1'b1;
      step(1);
   endtask

   task automatic t_edge_coalesce_r3();
      mask[4] = 1'b0; step(1);
      line_in[4] = 1'b1; step(1);
      line_in[4] = 1'b0; step(1);
      line_in[4] = 1'b1; step(1);
      chk(coal_pulse[4] == 1'b0, "R3 queued rise not coalesced", 64'(coal_pulse[4]), 0);
      line_in[4] = 1'b0; step(1);
      line_in[4] = 1'b1; step(1);
      chk(coal_pulse[4] == 1'b1, "R3 third rise coalesced", 64'(coal_pulse[4]), 1);
      line_in[4] = 1'b0;
      expect_msg(4, "R3 first delivery");
      expect_msg(4, "R3 second delivery");
      expect_none("R3 coalesced rise dropped");
   endtask

   task automatic t_mask_r5();
      line_in[6] = 1'b1; step(1);
      chk(coal_pulse[6] == 1'b0, "R5 masked pin no coalesce", 64'(coal_pulse[6]), 0);
      step(2);
      expect_none("R5 masked pin no delivery");
      line_in[6] = 1'b0;
   endtask

   task automatic t_level_remote_r4();
      b_vec[7] = 8'h47; trig[7] = 1'b1; mask[7] = 1'b0; step(1);
      line_in[7] = 1'b1; step(2);
      expect_msg(7, "R4 level pin delivers");
      line_in[7] = 1'b0; step(1);
      line_in[7] = 1'b1; step(1);
      chk(coal_pulse[7] == 1'b1, "R4 blocked rise coalesced", 64'(coal_pulse[7]), 1);
      step(2);
      expect_none("R4 no delivery while remote set");
   endtask

   task automatic t_eoi_r7();
      eoi_pulse(8'h48, 1'b1); step(2);
      expect_none("R7 non-matching vector ignored");
      eoi_pulse(8'h47, 1'b0); step(2);
      expect_none("R7 edge-type EOI no redelivery");
      line_in[7] = 1'b0; step(1);
      line_in[7] = 1'b1; step(1);
      chk(coal_pulse[7] == 1'b1, "R7 edge-type EOI keeps remote", 64'(coal_pulse[7]), 1);
      step(1);
      eoi_pulse(8'h47, 1'b1); step(1);
      expect_msg(7, "R7 level EOI redelivers");
      line_in[7] = 1'b0; step(1);
      eoi_pulse(8'h47, 1'b1); step(2);
      expect_none("R7 no redelivery with request clear");
      // two pins sharing a vector
      b_vec[14] = 8'h60; b_vec[15] = 8'h60;
      trig[14] = 1'b1; trig[15] = 1'b1; mask[14] = 1'b0; mask[15] = 1'b0; step(1);
      line_in[14] = 1'b1; line_in[15] = 1'b1; step(2);
      expect_msg(14, "R7 shared vector first");
      expect_msg(15, "R7 shared vector second");
      eoi_pulse(8'h60, 1'b1); step(1);
      expect_msg(14, "R7 EOI serves all matches, low pin");
      expect_msg(15, "R7 EOI serves all matches, high pin");
      line_in[14] = 1'b0; line_in[15] = 1'b0; step(1);
   endtask

   task automatic t_strobe_r8();
      trig[9] = 1'b1; mask[9] = 1'b0; step(1);
      line_in[9] = 1'b1; step(2);
      expect_msg(9, "R8 level pin first delivery");
      strobe[9] = 1'b1; step(1); strobe[9] = 1'b0; step(1);
      expect_msg(9, "R8 strobe redelivers");
      strobe[3] = 1'b1; strobe[7] = 1'b1; step(1);
      strobe[3] = 1'b0; strobe[7] = 1'b0; step(2);
      expect_none("R8 strobe ignored on edge pin and idle level pin");
      line_in[9] = 1'b0; step(1);
   endtask

   task automatic t_order_r9();
      mask[10] = 1'b0; mask[11] = 1'b0; mask[12] = 1'b0; step(1);
      line_in[12] = 1'b1; line_in[10] = 1'b1; line_in[11] = 1'b1;
      step(2);
      chk(msg_valid && msg_pin == 5'd10, "R9 lowest pin first", 64'(msg_pin), 64'd10);
      step(3);
      chk(msg_valid && msg_pin == 5'd10 && msg_vector == b_vec[10], "R9 held during stall",
          64'(msg_vector), 64'(b_vec[10]));
      expect_msg(10, "R9 order 1");
      expect_msg(11, "R9 order 2");
      expect_msg(12, "R9 order 3");
      expect_none("R9 queue drained");
      line_in[10] = 1'b0; line_in[11] = 1'b0; line_in[12] = 1'b0; step(1);
   endtask

   task automatic t_reset_mid_r11();
      mask[16] = 1'b0; step(1);
      line_in[16] = 1'b1; step(2);
      chk(msg_valid == 1'b1, "R11 message pending before reset", 64'(msg_valid), 1);
      rst_n = 1'b0; step(1);
      expect_none("R11 reset drops message");
      rst_n = 1'b1; step(2);
      expect_msg(16, "R11 request bit cleared, active line rises again");
   endtask

   initial begin
      line_in = '0; pol = '0; trig = '0; mask = '1; strobe = '0;
      eoi_valid = 1'b0; eoi_level = 1'b0; eoi_vector = '0; msg_ready = 1'b0;
      for (int p = 0; p < NP; p++) begin
         b_vec[p] = 8'(8'h20 + p);
         b_dst[p] = 8'(8'h80 + p);
         b_dlv[p] = 3'(p);
         dmode[p] = p[0];
      end
      step(2);
      t_reset_state();
      rst_n = 1'b1;
      step(2);
      t_vec_map_r10();
      t_edge_polarity_r1_r2();
      t_edge_coalesce_r3();
      t_mask_r5();
      t_level_remote_r4();
      t_eoi_r7();
      t_strobe_r8();
      t_order_r9();
      t_reset_mid_r11();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule